// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the Moore state machine that steps a multi-cycle processor datapath through the register transfers of each instruction. Every instruction starts with a fetch step and then a decode/operand-read step. After that, the six-bit opcode chooses a class-specific path through a small set of 4-bit state codes. The path for the compare-and-branch instruction also depends on the datapath's equality flag. When a path finishes, the sequencer returns to fetch.

Each state asserts a fixed set of control points: register load enables, program counter select, immediate extension mode, ALU operand source and function, memory strobes, and register file write controls. A transfer named by a state happens on the clock edge that leaves that state. The outputs are registered. They are loaded from the decode of the next state, so they change on the same edge as the state code and have no combinational path from the inputs.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in fetch (state code 0000) on the next clock edge, even in the middle of an instruction. The outputs then show the fetch controls.
- R2: Fetch (0000) asserts only the instruction memory read and the instruction register load. It always moves to decode (0001).
- R3: Decode (0001) asserts only the A and B operand loads. From decode, opcode 000100 goes to 0010 when equal=1 and to 0011 when equal=0. Opcode 000000 goes to 0100, 001101 goes to 0110, 100011 goes to 1000, and 101011 goes to 1011.
- R4: State 0010 asserts the PC load with pc_sel=1 (branch target) and sign extension. State 0011 asserts the PC load with pc_sel=0 (increment).
- R5: The register-register path is 0100 then 0101. 0100 loads R with ALU function code 2 (function field) and register operand B. 0101 writes the register file with rd as destination and the ALU result as source, and loads the PC.
- R6: The OR-immediate path is 0110 then 0111. 0110 loads R with ALU function code 1 (OR), an immediate operand and zero extension. 0111 writes the register file with rt as destination and loads the PC.
- R7: The load path is 1000, 1001, 1010. 1000 loads R with ALU function code 0 (add) and a sign-extended immediate. 1001 reads data memory into M. 1010 writes the register file with rt as destination and memory data as source, and loads the PC.
- R8: The store path is 1011 then 1100. 1011 computes the address in the same way as 1000. 1100 writes data memory and loads the PC.
- R9: States 0010, 0011, 0101, 0111, 1010 and 1100 always return to fetch.
- R10: Any other opcode at decode returns to fetch with no other control asserted. The unused codes 1101 to 1111 also return to fetch.
- R11: The data memory read and write are never asserted together. A PC load is always followed by fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| equal | input | 1 | Operand equality flag from the datapath |
| state_o | output | 4 | Current state code |
| ir_en | output | 1 | Instruction register load |
| a_en | output | 1 | Operand A register load |
| b_en | output | 1 | Operand B register load |
| r_en | output | 1 | ALU result register load |
| m_en | output | 1 | Memory data register load |
| pc_en | output | 1 | Program counter load |
| pc_sel | output | 1 | 0 = PC+4, 1 = branch target |
| ext_sign | output | 1 | 1 = sign-extend immediate, 0 = zero-extend |
| alu_src_imm | output | 1 | ALU second operand: 1 = immediate, 0 = B |
| alu_fn | output | 2 | 0 add, 1 OR, 2 function field |
| imem_rd | output | 1 | Instruction memory read |
| dmem_rd | output | 1 | Data memory read |
| dmem_wr | output | 1 | Data memory write |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination register: 1 = rd, 0 = rt |
| rf_src_mem | output | 1 | Write data: 1 = M, 0 = R |

## Verification
The state code is visible at the ports, and every control output depends only on that state. A wrong dispatch or a wrong return therefore shows up on the first clock edge after the faulty transition, as a mismatch in both the state code and the control bundle. A state that asserts a wrong control point is seen in the same cycle as that state. Decode is where the opcode and the equality flag are sampled, so it gets the most attention: both branch outcomes, every legal class, illegal opcodes, and a reset applied inside an instruction are all run against a behavioural model on every clock.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    S_FETCH    = 4'b0000,
    S_DECODE   = 4'b0001,
    S_BR_TAKE  = 4'b0010,
    S_BR_SKIP  = 4'b0011,
    S_RR_EXEC  = 4'b0100,
    S_RR_WB    = 4'b0101,
    S_ORI_EXEC = 4'b0110,
    S_ORI_WB   = 4'b0111,
    S_LD_ADDR  = 4'b1000,
    S_LD_MEM   = 4'b1001,
    S_LD_WB    = 4'b1010,
    S_ST_ADDR  = 4'b1011,
    S_ST_MEM   = 4'b1100,
    S_SPARE_D  = 4'b1101,
    S_SPARE_E  = 4'b1110,
    S_SPARE_F  = 4'b1111
  } state_e;

  localparam logic [1:0] FN_ADD = 2'd0;
  localparam logic [1:0] FN_OR  = 2'd1;
  localparam logic [1:0] FN_FUN = 2'd2;

  typedef struct packed {
    logic       ir_en;
    logic       a_en;
    logic       b_en;
    logic       r_en;
    logic       m_en;
    logic       pc_en;
    logic       pc_sel;
    logic       ext_sign;
    logic       alu_src_imm;
    logic [1:0] alu_fn;
    logic       imem_rd;
    logic       dmem_rd;
    logic       dmem_wr;
    logic       rf_wr;
    logic       rf_dst_rd;
    logic       rf_src_mem;
  } ctrl_t;

endpackage

// File: rtl/mcyc_next_state.sv
module mcyc_next_state
  import mcyc_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_RR  = 6'b000000,
  parameter logic [OP_W-1:0] OP_BEQ = 6'b000100,
  parameter logic [OP_W-1:0] OP_ORI = 6'b001101,
  parameter logic [OP_W-1:0] OP_LD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_ST  = 6'b101011
) (
  input  state_e          cur,
  input  logic [OP_W-1:0] opcode,
  input  logic            equal,
  output state_e          nxt
);

  state_e dispatch;

  // Class dispatch, used only when leaving decode
  always_comb begin
    if (opcode == OP_BEQ)      dispatch = equal ? S_BR_TAKE : S_BR_SKIP;
    else if (opcode == OP_RR)  dispatch = S_RR_EXEC;
    else if (opcode == OP_ORI) dispatch = S_ORI_EXEC;
    else if (opcode == OP_LD)  dispatch = S_LD_ADDR;
    else if (opcode == OP_ST)  dispatch = S_ST_ADDR;
    else                       dispatch = S_FETCH;
  end

  always_comb begin
    case (cur)
      S_FETCH:    nxt = S_DECODE;
      S_DECODE:   nxt = dispatch;
      S_RR_EXEC:  nxt = S_RR_WB;
      S_ORI_EXEC: nxt = S_ORI_WB;
      S_LD_ADDR:  nxt = S_LD_MEM;
      S_LD_MEM:   nxt = S_LD_WB;
      S_ST_ADDR:  nxt = S_ST_MEM;
      default:    nxt = S_FETCH;   // terminal and spare codes
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl_decode.sv
module mcyc_ctrl_decode
  import mcyc_pkg::*;
(
  input  state_e st,
  output ctrl_t  ctl
);

  always_comb begin
    ctl = '0;
    case (st)
      S_FETCH: begin
        ctl.imem_rd = 1'b1;
        ctl.ir_en   = 1'b1;
      end
      S_DECODE: begin
        ctl.a_en = 1'b1;
        ctl.b_en = 1'b1;
      end
      S_BR_TAKE: begin
        ctl.pc_en    = 1'b1;
        ctl.pc_sel   = 1'b1;
        ctl.ext_sign = 1'b1;
      end
      S_BR_SKIP: begin
        ctl.pc_en = 1'b1;
      end
      S_RR_EXEC: begin
        ctl.r_en   = 1'b1;
        ctl.alu_fn = FN_FUN;
      end
      S_RR_WB: begin
        ctl.rf_wr     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
        ctl.pc_en     = 1'b1;
      end
      S_ORI_EXEC: begin
        ctl.r_en        = 1'b1;
        ctl.alu_src_imm = 1'b1;
        ctl.alu_fn      = FN_OR;
      end
      S_ORI_WB: begin
        ctl.rf_wr = 1'b1;
        ctl.pc_en = 1'b1;
      end
      S_LD_ADDR, S_ST_ADDR: begin
        ctl.r_en        = 1'b1;
        ctl.alu_src_imm = 1'b1;
        ctl.ext_sign    = 1'b1;
        ctl.alu_fn      = FN_ADD;
      end
      S_LD_MEM: begin
        ctl.dmem_rd = 1'b1;
        ctl.m_en    = 1'b1;
      end
      S_LD_WB: begin
        ctl.rf_wr      = 1'b1;
        ctl.rf_src_mem = 1'b1;
        ctl.pc_en      = 1'b1;
      end
      S_ST_MEM: begin
        ctl.dmem_wr = 1'b1;
        ctl.pc_en   = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter int OP_W    = 6,
  parameter bit REG_OUT = 1'b1,
  parameter logic [OP_W-1:0] OP_RR  = 6'b000000,
  parameter logic [OP_W-1:0] OP_BEQ = 6'b000100,
  parameter logic [OP_W-1:0] OP_ORI = 6'b001101,
  parameter logic [OP_W-1:0] OP_LD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_ST  = 6'b101011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              equal,
  output logic [STATE_W-1:0] state_o,
  output logic              ir_en,
  output logic              a_en,
  output logic              b_en,
  output logic              r_en,
  output logic              m_en,
  output logic              pc_en,
  output logic              pc_sel,
  output logic              ext_sign,
  output logic              alu_src_imm,
  output logic [1:0]        alu_fn,
  output logic              imem_rd,
  output logic              dmem_rd,
  output logic              dmem_wr,
  output logic              rf_wr,
  output logic              rf_dst_rd,
  output logic              rf_src_mem
);

  state_e state_q;
  state_e state_d;
  ctrl_t  ctl;

  mcyc_next_state #(
    .OP_W(OP_W), .OP_RR(OP_RR), .OP_BEQ(OP_BEQ),
    .OP_ORI(OP_ORI), .OP_LD(OP_LD), .OP_ST(OP_ST)
  ) u_next (
    .cur    (state_q),
    .opcode (opcode),
    .equal  (equal),
    .nxt    (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_FETCH;
    else     state_q <= state_d;
  end

  generate
    if (REG_OUT) begin : g_reg_out
      state_e dec_in;
      ctrl_t  ctl_d;
      ctrl_t  ctl_q;
      assign dec_in = rst ? S_FETCH : state_d;
      mcyc_ctrl_decode u_dec (.st(dec_in), .ctl(ctl_d));
      always_ff @(posedge clk) ctl_q <= ctl_d;
      assign ctl = ctl_q;
    end else begin : g_comb_out
      mcyc_ctrl_decode u_dec (.st(state_q), .ctl(ctl));
    end
  endgenerate

  assign state_o     = state_q;
  assign ir_en       = ctl.ir_en;
  assign a_en        = ctl.a_en;
  assign b_en        = ctl.b_en;
  assign r_en        = ctl.r_en;
  assign m_en        = ctl.m_en;
  assign pc_en       = ctl.pc_en;
  assign pc_sel      = ctl.pc_sel;
  assign ext_sign    = ctl.ext_sign;
  assign alu_src_imm = ctl.alu_src_imm;
  assign alu_fn      = ctl.alu_fn;
  assign imem_rd     = ctl.imem_rd;
  assign dmem_rd     = ctl.dmem_rd;
  assign dmem_wr     = ctl.dmem_wr;
  assign rf_wr       = ctl.rf_wr;
  assign rf_dst_rd   = ctl.rf_dst_rd;
  assign rf_src_mem  = ctl.rf_src_mem;

  AST_RESET_FETCH: assert property (@(posedge clk) rst |=> state_q == S_FETCH); // R1
  AST_FETCH_DECODE: assert property (@(posedge clk) disable iff (rst)
    state_q == S_FETCH |=> state_q == S_DECODE); // R2
  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE && opcode == OP_BEQ && equal) |=> state_q == S_BR_TAKE); // R3
  AST_BR_SKIP: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE && opcode == OP_BEQ && !equal) |=> state_q == S_BR_SKIP); // R3
  AST_LOAD_SEQ: assert property (@(posedge clk) disable iff (rst)
    state_q == S_LD_ADDR |=> state_q == S_LD_MEM); // R7
  AST_STORE_SEQ: assert property (@(posedge clk) disable iff (rst)
    state_q == S_ST_ADDR |=> state_q == S_ST_MEM); // R8
  AST_TERMINAL_RETURN: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {S_BR_TAKE, S_BR_SKIP, S_RR_WB, S_ORI_WB, S_LD_WB, S_ST_MEM})
    |=> state_q == S_FETCH); // R9
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr)); // R11
  AST_PC_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    pc_en |=> state_q == S_FETCH); // R11

endmodule

// File: tb/mcyc_ctrl_bench.sv
`timescale 1ns/1ps
module mcyc_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;
  logic       equal;
  logic [3:0] state_o;
  logic ir_en, a_en, b_en, r_en, m_en, pc_en, pc_sel, ext_sign, alu_src_imm;
  logic [1:0] alu_fn;
  logic imem_rd, dmem_rd, dmem_wr, rf_wr, rf_dst_rd, rf_src_mem;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  int prev   = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mcyc_ctrl u_mcyc_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .equal(equal), .state_o(state_o),
    .ir_en(ir_en), .a_en(a_en), .b_en(b_en), .r_en(r_en), .m_en(m_en),
    .pc_en(pc_en), .pc_sel(pc_sel), .ext_sign(ext_sign),
    .alu_src_imm(alu_src_imm), .alu_fn(alu_fn), .imem_rd(imem_rd),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .rf_wr(rf_wr),
    .rf_dst_rd(rf_dst_rd), .rf_src_mem(rf_src_mem)
  );

  // Reference next state from R2, R3, R5-R10
  function automatic int ref_next(int s, logic [5:0] op, logic eq);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'd4)  return eq ? 2 : 3;
        if (op == 6'd0)  return 4;
        if (op == 6'd13) return 6;
        if (op == 6'd35) return 8;
        if (op == 6'd43) return 11;
        return 0;
      end
      4: return 5;
      6: return 7;
      8: return 9;
      9: return 10;
      11: return 12;
      default: return 0;
    endcase
  endfunction

  // Order: ir a b r m pc pcsel ext imm fn[1:0] imem drd dwr rfwr dst src
  function automatic logic [16:0] ref_ctl(int s);
    case (s)
      0:  return 17'b1_0_0_0_0_0_0_0_0_00_1_0_0_0_0_0;
      1:  return 17'b0_1_1_0_0_0_0_0_0_00_0_0_0_0_0_0;
      2:  return 17'b0_0_0_0_0_1_1_1_0_00_0_0_0_0_0_0;
      3:  return 17'b0_0_0_0_0_1_0_0_0_00_0_0_0_0_0_0;
      4:  return 17'b0_0_0_1_0_0_0_0_0_10_0_0_0_0_0_0;
      5:  return 17'b0_0_0_0_0_1_0_0_0_00_0_0_0_1_1_0;
      6:  return 17'b0_0_0_1_0_0_0_0_1_01_0_0_0_0_0_0;
      7:  return 17'b0_0_0_0_0_1_0_0_0_00_0_0_0_1_0_0;
      8, 11: return 17'b0_0_0_1_0_0_0_1_1_00_0_0_0_0_0_0;
      9:  return 17'b0_0_0_0_1_0_0_0_0_00_0_1_0_0_0_0;
      10: return 17'b0_0_0_0_0_1_0_0_0_00_0_0_0_1_0_1;
      12: return 17'b0_0_0_0_0_1_0_0_0_00_0_0_1_0_0_0;
      default: return 17'b0;
    endcase
  endfunction

  function automatic string tag_of(int s, int p, bit in_reset);
    if (in_reset) return "R1";
    if (s == 0 && p == 1) return "R10";
    if (s == 0 && p != 0) return "R9";
    case (s)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      8, 9, 10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic tick();
    int nx;
    bit rs;
    logic [16:0] got;
    logic [16:0] exp;
    rs = rst;
    nx = rs ? 0 : ref_next(model, opcode, equal);
    @(negedge clk);
    prev  = model;
    model = nx;
    got = {ir_en, a_en, b_en, r_en, m_en, pc_en, pc_sel, ext_sign, alu_src_imm,
           alu_fn, imem_rd, dmem_rd, dmem_wr, rf_wr, rf_dst_rd, rf_src_mem};
    exp = ref_ctl(model);
    checks++;
    if (state_o !== 4'(model) || got !== exp) begin
      fails++;
      $display("FAIL %s: state=%b ctl=%b expected state=%b ctl=%b",
               tag_of(model, prev, rs), state_o, got, 4'(model), exp);
    end
    checks++;
    if (dmem_rd === 1'b1 && dmem_wr === 1'b1) begin
      fails++;
      $display("FAIL R11: dmem_rd=1 dmem_wr=1 expected not both");
    end
  endtask

  task automatic run_instr(logic [5:0] op, logic eq);
    opcode = op;
    equal  = eq;
    tick();
    while (model != 0) tick();
  endtask

  initial begin
    rst = 1'b1;
    opcode = 6'd0;
    equal = 1'b0;
    @(negedge clk);
    tick();  // R1: reset state
    tick();
    rst = 1'b0;
    run_instr(6'd0, 1'b0);    // R5
    run_instr(6'd4, 1'b1);    // R3 R4 taken
    run_instr(6'd4, 1'b0);    // R3 R4 not taken
    run_instr(6'd13, 1'b1);   // R6
    run_instr(6'd35, 1'b0);   // R7
    run_instr(6'd43, 1'b1);   // R8
    run_instr(6'd2, 1'b0);    // R10 illegal
    run_instr(6'd63, 1'b1);   // R10 illegal
    // R1: reset inside a load
    opcode = 6'd35;
    tick(); tick(); tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    for (int i = 0; i < 300; i++) begin
      logic [5:0] pick;
      case ($urandom_range(0, 5))
        0: pick = 6'd0;
        1: pick = 6'd4;
        2: pick = 6'd13;
        3: pick = 6'd35;
        4: pick = 6'd43;
        default: pick = 6'($urandom);
      endcase
      run_instr(pick, 1'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule